// File: doc/BRIEF.md
# MDIO management frame controller

This block is the master side of a PHY management serial link. Software sets a clock setting and then writes one packed 32-bit command word. That word holds the start code, the opcode, the PHY address, the register number, the turnaround pattern and the write data. The block generates the management clock (MDC) from the system clock. It sends a preamble of ones and then shifts the whole command word out on the bidirectional data line, most significant bit first.

For a read, the block hands the line over to the PHY during the turnaround. It then captures the 16 returned bits into the low half of its data register. At the end of every frame it raises a sticky completion event. Software clears that event by writing a one to it. Only one command is in flight at a time. Command and clock-setting writes made while a frame runs are dropped.

Top module: `mdio_mgmt`

## Requirements
- R1: A command write made while idle, with a nonzero clock setting S, starts a frame at once. `busy_o` then stays high for exactly 128·S system clocks.
- R2: During a frame the data line carries 32 ones, then command bits 31 down to 0. Each bit is held for one MDC period and changes only where MDC falls. When idle the line value is 1.
- R3: MDC has a period of 2·S system clocks. Within each bit it is low for the first S clocks and high for the second S clocks. It stays low while idle.
- R4: The command word is packed as start code 01 in bits 31:30, opcode in bits 29:28 (10 read, 01 write), PHY address in bits 27:23, register in bits 22:18, turnaround 10 in bits 17:16 and write data in bits 15:0. Only opcode 10 makes a read.
- R5: `mdio_oe_o` is high for the whole of a write frame. In a read frame it goes low from the bit that carries command bit 16 to the end of the frame. It is low while idle.
- R6: In a read, the input is sampled at the last 16 MDC rising edges, first bit into bit 15. At completion those 16 bits replace data register bits 15:0, and bits 31:16 keep the command. After a write the register still holds the command word.
- R7: The event flag rises on the same clock edge on which `busy_o` falls. Writing 1 to the flag clears it, and writing 0 leaves it unchanged.
- R8: A read from a PHY that never drives the line (the line stays high) returns 0xFFFF in bits 15:0.
- R9: With a clock setting of 0, a command write still loads the data register, but no frame starts: `busy_o` stays low and MDC stays low.
- R10: Command writes and clock-setting writes made while `busy_o` is high are ignored.
- R11: After reset the data register is 0, the event flag is 0, the clock setting is 0, and `busy_o`, MDC and `mdio_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command/data register |
| cmd_wdata | input | 32 | Packed command word |
| speed_we | input | 1 | Write strobe for the clock setting |
| speed_wdata | input | DIV_W | Clock setting S (MDC period 2·S clocks, 0 = off) |
| evt_we | input | 1 | Write strobe for the event flag |
| evt_wdata | input | 1 | 1 clears the event flag |
| data_o | output | 32 | Data register contents |
| evt_o | output | 1 | Completion event flag |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A command write seen at clock edge n sets `busy_o` at edge n. MDC then first rises S edges later. Each line bit changes every 2·S edges, and the event and read data appear on edge n+128·S. The bench model advances its own clock count at every rising edge from the strobes it drove. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due. The PHY stimulus changes only on falling edges, so the captured bits are stable when the design samples them.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int CMD_W     = 32;
  localparam int RDATA_W   = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int SEL_W     = $clog2(CMD_W);
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam int TA2_BIT   = 16;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = run_i && (cnt_q == half_i - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;

  // R3: clock parked low whenever no frame runs
  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !mdc_q);
  // R3: clock level only changes on a half-period boundary
  a_r3_mdc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_mgmt_shifter.sv
module mdio_mgmt_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [RDATA_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_PRE   = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(FRAME_LEN - 1 - TA2_BIT);
  localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(FRAME_LEN - RDATA_W);

  logic               busy_q, busy_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [CMD_W-1:0]   frame_q, frame_d;
  logic               rd_q, rd_d;
  logic [RDATA_W-1:0] cap_q, cap_d;
  logic               last;
  logic [SEL_W-1:0]   sel;

  assign last   = (idx_q == IDX_LAST);
  assign done_o = busy_q && fall_i && last;

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    cap_d   = cap_q;
    if (start_i) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      frame_d = cmd_i;
      rd_d    = (cmd_i[OP_HI:OP_LO] == OP_READ);
      cap_d   = '0;
    end else if (busy_q) begin
      if (fall_i) begin
        if (last) busy_d = 1'b0;
        else      idx_d  = idx_q + IDX_W'(1);
      end
      if (rise_i && rd_q && (idx_q >= IDX_DATA0))
        cap_d = {cap_q[RDATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      cap_q   <= cap_d;
    end
  end

  assign sel       = SEL_W'(IDX_LAST - idx_q);
  assign mdio_o    = !busy_q || (idx_q < IDX_PRE) || frame_q[sel];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= IDX_TA2));
  assign busy_o    = busy_q;
  assign rdata_o   = cap_q;

  // R1: a new frame is only launched from idle
  a_r1_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
  // R2: bit position advances only on a falling clock edge
  a_r2_idx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_i) |=> $stable(idx_q));
  // R6: captured data only moves on a rising clock edge
  a_r6_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !start_i) |=> $stable(cap_q));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  input  logic             speed_we,
  input  logic [DIV_W-1:0] speed_wdata,
  input  logic             evt_we,
  input  logic             evt_wdata,
  output logic [31:0]      data_o,
  output logic             evt_o,
  output logic             busy_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [CMD_W-1:0]   data_q, data_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               evt_q, evt_d;
  logic               busy, done, start, rise, fall;
  logic [RDATA_W-1:0] rdata;

  assign start = cmd_we && !busy && (div_q != '0);

  always_comb begin
    data_d = data_q;
    div_d  = div_q;
    evt_d  = evt_q;
    if (cmd_we && !busy)
      data_d = cmd_wdata;
    else if (done && (data_q[OP_HI:OP_LO] == OP_READ))
      data_d = {data_q[CMD_W-1:RDATA_W], rdata};
    if (speed_we && !busy)
      div_d = speed_wdata;
    if (evt_we && evt_wdata)
      evt_d = 1'b0;
    if (done)
      evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      div_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      div_q  <= div_d;
      evt_q  <= evt_d;
    end
  end

  mdio_mgmt_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .half_i (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_mgmt_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .cmd_i     (cmd_wdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (rdata)
  );

  assign data_o = data_q;
  assign evt_o  = evt_q;
  assign busy_o = busy;

  // R7: completion always leaves the event raised
  a_r7_evt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt_q);
  // R9: a frame never runs with a zero clock setting
  a_r9_busy_needs_speed: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_q != '0));
  // R10: clock setting frozen during a frame
  a_r10_speed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_q));
  // R10: data register untouched mid-frame
  a_r10_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(data_q));
endmodule

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        speed_we = 1'b0;
  logic [7:0]  speed_wdata = '0;
  logic        evt_we = 1'b0;
  logic        evt_wdata = 1'b0;
  logic        mdio_in = 1'b1;
  logic [31:0] data_o;
  logic        evt_o, busy_o, mdc_o, mdio_o, mdio_oe_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_busy = 0;
  int          m_t = 0;
  int          m_d = 0;
  int          m_div = 0;
  logic [31:0] m_cmd = '0;
  bit          m_rd = 0;
  logic [15:0] m_cap = '0;
  logic [31:0] m_data = '0;
  bit          m_evt = 0;
  bit          phy_on = 0;
  logic [15:0] phy_resp = '0;

  always #2 clk = ~clk;

  mdio_mgmt #(.DIV_W(8)) i_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .speed_we(speed_we), .speed_wdata(speed_wdata), .evt_we(evt_we),
    .evt_wdata(evt_wdata), .data_o(data_o), .evt_o(evt_o), .busy_o(busy_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_in)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit was_busy;
    bit fin;
    int k;
    was_busy = m_busy;
    fin = 0;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_div = 0; m_data = '0; m_evt = 0; m_cap = '0;
    end else begin
      if (m_busy) begin
        m_t++;
        k = m_t / (2 * m_d);
        if ((m_t % (2 * m_d)) == m_d && m_rd && k >= 48)
          m_cap = {m_cap[14:0], mdio_in};
        if (m_t == 128 * m_d) begin
          m_busy = 0;
          fin = 1;
          if (m_rd) m_data[15:0] = m_cap;
        end
      end
      if (evt_we && evt_wdata) m_evt = 0;
      if (fin) m_evt = 1;
      if (!was_busy && cmd_we) begin
        m_data = cmd_wdata;
        if (m_div != 0) begin
          m_busy = 1; m_t = 0; m_d = m_div; m_cmd = cmd_wdata;
          m_rd = (cmd_wdata[29:28] == 2'b10); m_cap = '0;
        end
      end
      if (!was_busy && speed_we) m_div = speed_wdata;
    end
  end

  always @(negedge clk) begin
    int k;
    bit e_mdc, e_out, e_oe;
    k = m_busy ? m_t / (2 * m_d) : 0;
    e_mdc = m_busy ? ((m_t / m_d) % 2 == 1) : 1'b0;
    e_out = !m_busy ? 1'b1 : (k < 32 ? 1'b1 : m_cmd[63 - k]);
    e_oe  = m_busy && !(m_rd && k >= 47);
    chk("R1 busy", {31'd0, busy_o}, {31'd0, m_busy});
    chk("R3 mdc", {31'd0, mdc_o}, {31'd0, e_mdc});
    chk("R2 mdio_o", {31'd0, mdio_o}, {31'd0, e_out});
    chk("R5 mdio_oe", {31'd0, mdio_oe_o}, {31'd0, e_oe});
    chk("R7 evt", {31'd0, evt_o}, {31'd0, m_evt});
    chk("R6 data", data_o, m_data);
    mdio_in = (phy_on && m_busy && m_rd && k >= 48 && k <= 63) ? phy_resp[63 - k] : 1'b1;
  end

  task automatic wr_cmd(logic [31:0] v);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_speed(logic [7:0] v);
    @(negedge clk); speed_we = 1'b1; speed_wdata = v;
    @(negedge clk); speed_we = 1'b0;
  endtask

  task automatic wr_evt(logic v);
    @(negedge clk); evt_we = 1'b1; evt_wdata = v;
    @(negedge clk); evt_we = 1'b0;
  endtask

  task automatic run_xfer(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 data", data_o, 32'h0);
    chk("R11 evt", {31'd0, evt_o}, 32'd0);
    chk("R11 busy", {31'd0, busy_o}, 32'd0);
    chk("R11 mdc", {31'd0, mdc_o}, 32'd0);
    chk("R11 oe", {31'd0, mdio_oe_o}, 32'd0);

    // R9 zero setting: register loads, nothing runs
    wr_cmd(32'h618A_0000);
    repeat (10) begin
      chk("R9 busy", {31'd0, busy_o}, 32'd0);
      chk("R9 mdc", {31'd0, mdc_o}, 32'd0);
      @(negedge clk);
    end
    chk("R9 data", data_o, 32'h618A_0000);

    // R4 write frame at S=2
    wr_speed(8'd2);
    wr_cmd(32'h5292_BEEF);
    run_xfer(n);
    chk("R1 length S=2", n, 32'd256);
    chk("R7 evt set", {31'd0, evt_o}, 32'd1);
    chk("R6 write keeps cmd", data_o, 32'h5292_BEEF);
    wr_evt(1'b0);
    chk("R7 write0 no effect", {31'd0, evt_o}, 32'd1);
    wr_evt(1'b1);
    chk("R7 write1 clears", {31'd0, evt_o}, 32'd0);

    // R6 read with PHY present at S=3, R10 writes ignored mid-frame
    phy_on = 1; phy_resp = 16'hA5C3;
    wr_speed(8'd3);
    wr_cmd(32'h618A_0000);
    repeat (20) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 32'h1234_5678; speed_we = 1'b1; speed_wdata = 8'd1;
    @(negedge clk);
    cmd_we = 1'b0; speed_we = 1'b0;
    chk("R10 data unchanged", data_o, 32'h618A_0000);
    chk("R10 still busy", {31'd0, busy_o}, 32'd1);
    run_xfer(n);
    chk("R6 read data", data_o, 32'h618A_A5C3);
    chk("R7 evt after read", {31'd0, evt_o}, 32'd1);
    wr_evt(1'b1);

    // R8 absent PHY at S=1
    phy_on = 0;
    wr_speed(8'd1);
    wr_cmd(32'h6FFE_0000);
    run_xfer(n);
    chk("R1 length S=1", n, 32'd128);
    chk("R8 absent phy", data_o, 32'h6FFE_FFFF);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule